// File: doc/BRIEF.md
# Serviced Watchdog Timer with Prescaler

The block guards a processor against software that stops running its main loop. A 16-bit down counter starts from a programmable timeout value. The counter is decremented once per system clock, or once every 65,536 clocks when the prescaler is switched on. Software keeps the counter from running out by writing a two-word key sequence to a service register. Each completed sequence reloads the counter from the timeout value and restarts the prescaler.

If the counter reaches zero, the block emits a one-cycle request. A mode bit routes that request either to the hard-reset controller or to a non-maskable machine-check interrupt input. The counter then stays at zero until it is serviced again or the block is reset.

Software reaches the block through a plain write strobe, an address, write data and combinational read data. A mode register holds the timeout and three mode bits, and a count register shows the live counter. The three mode bits accept only the first write after reset, so software that has gone astray cannot quietly turn the watchdog off.

Top module: `wdog_timer`

## Requirements
- R1: After reset the mode register (address 0) reads 0xFFFF0007 (timeout 0xFFFF, all three mode bits set), the count register reads 0x0000FFFF, and both request outputs are low.
- R2: With the enable bit (mode bit 0) set and the prescale bit (mode bit 1) clear, the counter decreases by one on every clock edge while it is above zero.
- R3: With both enable and prescale set, the counter decreases by one once every 2^PRESC_W clocks (65,536 by default), counted from the last service or reset.
- R4: With enable clear, neither the counter nor the prescaler changes, except through a service reload.
- R5: Writing the timeout field (mode register bits 31:16) leaves the running counter untouched. A completed service sequence loads the counter with the current timeout field and clears the prescaler.
- R6: A service sequence is a write of 0x556C to the service register (address 1) and then a write of 0xAA39 to it, with the keys compared on data bits 15:0. Any other value written there cancels a started sequence. Writes to other addresses neither start nor cancel one.
- R7: On the clock edge where the counter steps from 1 to 0, exactly one of the requests rises for one cycle. rst_req_o rises when the select bit (mode bit 2) is 1, and nmi_req_o rises when it is 0.
- R8: Once at zero, the counter stays at zero and raises no further request until it is serviced or reset.
- R9: Only the first mode-register write after reset changes the enable, prescale and select bits. The timeout field accepts every write.
- R10: When a service completes on the same edge where a decrement would bring the counter to zero, the reload wins and no request is raised. Reloading a timeout of zero also raises no request.
- R11: Reading the service register or address 3 returns zero. The count register returns the counter in bits 15:0, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 mode, 1 service, 2 count |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| rst_req_o | output | 1 | One-cycle hard-reset request on expiry |
| nmi_req_o | output | 1 | One-cycle machine-check interrupt request on expiry |

## Verification
The critical overlap is a service sequence finishing on the same edge where the decrementer would step from one to zero. The bench provokes it with a directed case: a short timeout, with the second key written so that it lands exactly on the expiry edge. It judges the outcome by reading back the reloaded count and confirming that no request rises in the following cycle. Random traffic mixes key writes, stray service writes and locked mode writes with short timeouts. This makes further collisions of service and expiry. Every cycle is compared against a reference model in the bench.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 32;
  localparam int KEY_W  = 16;

  localparam logic [REG_AW-1:0] ADDR_MODE = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_SVC  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CNT  = 2'd2;

  localparam logic [KEY_W-1:0] KEY_ARM  = 16'h556C;
  localparam logic [KEY_W-1:0] KEY_FIRE = 16'hAA39;

  localparam int MODE_EN_BIT  = 0;
  localparam int MODE_PRE_BIT = 1;
  localparam int MODE_SEL_BIT = 2;
  localparam int MODE_TO_LSB  = 16;

  typedef struct packed {
    logic sel_rst;
    logic pre;
    logic en;
  } wd_mode_t;
endpackage

// File: rtl/wdog_seq_detect.sv
module wdog_seq_detect
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] data_i,
  output logic             svc_o
);
  logic armed_q;

  assign svc_o = wr_i && armed_q && (data_i == KEY_FIRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (wr_i) armed_q <= (data_i == KEY_ARM);
  end

  p_arm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && data_i == KEY_ARM) |=> armed_q);
  p_cancel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && data_i != KEY_ARM) |=> !armed_q);
  p_idle_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(armed_q));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRESC_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam logic [PRESC_W-1:0] PMAX = {PRESC_W{1'b1}};

  logic [PRESC_W-1:0] psc_q;

  assign tick_o = run_i && (psc_q == PMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    psc_q <= '0;
    else if (clr_i) psc_q <= '0;
    else if (run_i) psc_q <= psc_q + 1'b1;
  end

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(psc_q));
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (psc_q == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             sel_rst_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rst_req_o,
  output logic             nmi_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             rst_q, nmi_q, fire;

  assign fire = !load_i && tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      if (load_i)                      cnt_q <= load_val_i;
      else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      rst_q <= fire && sel_rst_i;
      nmi_q <= fire && !sel_rst_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = rst_q;
  assign nmi_req_o = nmi_q;

  p_single_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q);
  p_single_nmi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_q |=> !nmi_q);
  p_one_route_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_q, nmi_q}));
  p_fire_at_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_q || nmi_q) |-> (cnt_q == '0));
  p_stay_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i) && !rst_q && !nmi_q));
  p_hold_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRESC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              rst_req_o,
  output logic              nmi_req_o
);
  wd_mode_t         mode_q;
  logic             lock_q;
  logic [CNT_W-1:0] timeout_q, cnt;
  logic             mode_wr, svc_wr, svc, psc_tick, dec_tick;

  assign mode_wr = reg_we_i && (reg_addr_i == ADDR_MODE);
  assign svc_wr  = reg_we_i && (reg_addr_i == ADDR_SVC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '{sel_rst: 1'b1, pre: 1'b1, en: 1'b1};
      lock_q    <= 1'b0;
      timeout_q <= '1;
    end else if (mode_wr) begin
      timeout_q <= reg_wdata_i[MODE_TO_LSB +: CNT_W];
      lock_q    <= 1'b1;
      if (!lock_q) begin
        mode_q.en      <= reg_wdata_i[MODE_EN_BIT];
        mode_q.pre     <= reg_wdata_i[MODE_PRE_BIT];
        mode_q.sel_rst <= reg_wdata_i[MODE_SEL_BIT];
      end
    end
  end

  wdog_seq_detect u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (svc_wr),
    .data_i (reg_wdata_i[KEY_W-1:0]),
    .svc_o  (svc)
  );

  wdog_prescaler #(.PRESC_W(PRESC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (mode_q.en && mode_q.pre),
    .clr_i  (svc),
    .tick_o (psc_tick)
  );

  assign dec_tick = mode_q.en && (mode_q.pre ? psc_tick : 1'b1);

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (mode_q.en),
    .tick_i     (dec_tick),
    .load_i     (svc),
    .load_val_i (timeout_q),
    .sel_rst_i  (mode_q.sel_rst),
    .cnt_o      (cnt),
    .rst_req_o  (rst_req_o),
    .nmi_req_o  (nmi_req_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_MODE: begin
        reg_rdata_o[MODE_TO_LSB +: CNT_W] = timeout_q;
        reg_rdata_o[MODE_EN_BIT]          = mode_q.en;
        reg_rdata_o[MODE_PRE_BIT]         = mode_q.pre;
        reg_rdata_o[MODE_SEL_BIT]         = mode_q.sel_rst;
      end
      ADDR_CNT: reg_rdata_o[CNT_W-1:0] = cnt;
      default:  reg_rdata_o = '0;
    endcase
  end

  p_mode_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && mode_wr) |=> (mode_q == $past(mode_q)));
  p_timeout_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> (timeout_q == $past(reg_wdata_i[MODE_TO_LSB +: CNT_W])));
  p_route_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> mode_q.sel_rst);
  p_route_nmi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o |-> !mode_q.sel_rst);
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  import wdog_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int PW = 4;
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = ADDR_CNT;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rst_req, nmi_req;

  int checks = 0;
  int fails = 0;
  int rst_pulses = 0;
  int nmi_pulses = 0;
  string tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.CNT_W(CW), .PRESC_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rst_req_o(rst_req), .nmi_req_o(nmi_req)
  );

  // reference model built from the requirements
  logic m_en, m_pre, m_sel, m_lock, m_arm, m_rst, m_nmi;
  logic [CW-1:0] m_to, m_cnt;
  logic [PW-1:0] m_psc;

  always @(posedge clk or negedge rst_n) begin
    logic svc, tick;
    if (!rst_n) begin
      m_en <= 1; m_pre <= 1; m_sel <= 1; m_lock <= 0; m_arm <= 0;
      m_rst <= 0; m_nmi <= 0; m_to <= '1; m_cnt <= '1; m_psc <= '0;
    end else begin
      svc  = we && addr == ADDR_SVC && m_arm && wdata[15:0] == KEY_FIRE;
      tick = m_en && (!m_pre || m_psc == PMAX);
      m_rst <= 0; m_nmi <= 0;
      if (svc) begin
        m_cnt <= m_to; m_psc <= '0;
      end else begin
        if (m_en && m_pre) m_psc <= m_psc + 1'b1;
        if (tick && m_cnt != 0) begin
          m_cnt <= m_cnt - 1'b1;
          if (m_cnt == 1) begin
            m_rst <= m_sel; m_nmi <= !m_sel;
          end
        end
      end
      if (we && addr == ADDR_SVC) m_arm <= (wdata[15:0] == KEY_ARM);
      if (we && addr == ADDR_MODE) begin
        m_to <= wdata[31:16];
        m_lock <= 1;
        if (!m_lock) begin
          m_en <= wdata[0]; m_pre <= wdata[1]; m_sel <= wdata[2];
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      ADDR_MODE: exp_rd = {m_to, 13'd0, m_sel, m_pre, m_en};
      ADDR_CNT:  exp_rd = {16'd0, m_cnt};
      default:   exp_rd = '0;
    endcase
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic compare();
    chk(tag, rdata, exp_rd(addr));
    chk("R7 rst_req", {31'd0, rst_req}, {31'd0, m_rst});
    chk("R7 nmi_req", {31'd0, nmi_req}, {31'd0, m_nmi});
    if (rst_req === 1'b1) rst_pulses++;
    if (nmi_req === 1'b1) nmi_pulses++;
  endtask

  task automatic cyc(input logic w, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    compare();
    we = w; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, ADDR_CNT, '0);
  endtask

  task automatic service();
    cyc(1, ADDR_SVC, {16'd0, KEY_ARM});
    cyc(1, ADDR_SVC, {16'd0, KEY_FIRE});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; we = 0; addr = ADDR_CNT; wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    rst_pulses = 0; nmi_pulses = 0;
  endtask

  function automatic logic [31:0] mode_word(input logic [15:0] to, input logic sel,
                                            input logic pre, input logic en);
    return {to, 13'd0, sel, pre, en};
  endfunction

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    compare();
    we = 0; addr = a; wdata = '0;
    #1 v = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'h5EED_0042));

    // R1 reset state
    do_reset();
    peek(ADDR_MODE, v); chk("R1 mode reset", v, 32'hFFFF_0007);
    peek(ADDR_CNT, v);  chk("R1 count reset", v, 32'h0000_FFFF);
    chk("R1 rst_req low", {31'd0, rst_req}, 32'd0);
    chk("R1 nmi_req low", {31'd0, nmi_req}, 32'd0);
    peek(ADDR_SVC, v);  chk("R11 service reads zero", v, 32'd0);
    peek(2'd3, v);      chk("R11 addr3 reads zero", v, 32'd0);

    // R5 timeout write does not disturb counter; R9 lock
    tag = "R5";
    cyc(1, ADDR_MODE, mode_word(16'd5, 1'b1, 1'b0, 1'b1));
    peek(ADDR_CNT, v); chk("R5 count unchanged by timeout write", v, 32'h0000_FFFF);
    cyc(1, ADDR_MODE, mode_word(16'd6, 1'b0, 1'b1, 1'b0));
    peek(ADDR_MODE, v); chk("R9 mode bits locked, timeout updated", v, 32'h0006_0005);
    cyc(1, ADDR_MODE, mode_word(16'd4, 1'b0, 1'b0, 1'b0));

    // R2 and R7/R8 expiry to reset
    tag = "R2";
    service();
    peek(ADDR_CNT, v); chk("R5 reload value", v, 32'd4);
    peek(ADDR_CNT, v); chk("R2 one step per clock", v, 32'd3);
    idle(20);
    peek(ADDR_CNT, v); chk("R8 counter stays zero", v, 32'd0);
    chk("R8 exactly one rst pulse", rst_pulses, 32'd1);
    chk("R7 no nmi pulse with select=1", nmi_pulses, 32'd0);

    // R6 sequence handling
    tag = "R6";
    cyc(1, ADDR_SVC, {16'd0, KEY_ARM});
    cyc(1, ADDR_MODE, mode_word(16'd9, 1'b0, 1'b0, 1'b0));
    cyc(1, ADDR_SVC, {16'd0, KEY_FIRE});
    peek(ADDR_CNT, v); chk("R6 other address keeps sequence", v, 32'd9);
    idle(15);
    cyc(1, ADDR_SVC, {16'd0, KEY_ARM});
    cyc(1, ADDR_SVC, 32'h0000_1234);
    cyc(1, ADDR_SVC, {16'd0, KEY_FIRE});
    peek(ADDR_CNT, v); chk("R6 stray value cancels sequence", v, 32'd0);

    // R10 service meets expiry on the same edge
    do_reset();
    tag = "R10";
    cyc(1, ADDR_MODE, mode_word(16'd3, 1'b0, 1'b0, 1'b1));
    service();                               // load at E0
    cyc(0, ADDR_CNT, '0);                    // E1 -> 2
    cyc(1, ADDR_SVC, {16'd0, KEY_ARM});      // E2 -> 1
    cyc(1, ADDR_SVC, {16'd0, KEY_FIRE});     // E3 reload beats expiry
    peek(ADDR_CNT, v); chk("R10 reload wins over expiry", v, 32'd3);
    chk("R10 no nmi on collision", {31'd0, nmi_req}, 32'd0);
    idle(10);
    chk("R7 one nmi after later expiry", nmi_pulses, 32'd1);
    cyc(1, ADDR_MODE, mode_word(16'd0, 1'b1, 1'b1, 1'b0));
    service();
    idle(3);
    chk("R10 zero reload raises nothing", nmi_pulses + rst_pulses, 32'd1);

    // R3 prescaler
    do_reset();
    tag = "R3";
    cyc(1, ADDR_MODE, mode_word(16'd2, 1'b1, 1'b1, 1'b1));
    service();
    idle(20);
    peek(ADDR_CNT, v); chk("R3 one step after prescale period", v, 32'd1);
    idle(14);
    peek(ADDR_CNT, v); chk("R3 zero after two periods", v, 32'd0);
    chk("R3 rst pulse after prescaled expiry", rst_pulses, 32'd1);

    // R4 disabled
    do_reset();
    tag = "R4";
    cyc(1, ADDR_MODE, mode_word(16'd7, 1'b1, 1'b0, 1'b0));
    peek(ADDR_CNT, v);
    idle(50);
    peek(ADDR_CNT, v2); chk("R4 count held when disabled", v2, v);
    service();
    idle(30);
    peek(ADDR_CNT, v); chk("R4 disabled after reload holds", v, 32'd7);

    // random traffic against the model
    for (int s = 0; s < 24; s++) begin
      logic [15:0] to;
      do_reset();
      tag = "R2";
      to = ($urandom_range(0, 9) == 0) ? 16'd0 : 16'($urandom_range(1, 40));
      cyc(1, ADDR_MODE, mode_word(to, 1'($urandom_range(0, 1)),
                                  ($urandom_range(0, 9) < 3),
                                  ($urandom_range(0, 3) != 0)));
      service();
      for (int i = 0; i < 300; i++) begin
        int r = $urandom_range(0, 99);
        if (r < 10)      cyc(1, ADDR_SVC, {16'($urandom), KEY_ARM});
        else if (r < 20) cyc(1, ADDR_SVC, {16'd0, KEY_FIRE});
        else if (r < 25) cyc(1, ADDR_SVC, $urandom);
        else if (r < 30) cyc(1, ADDR_MODE, {16'($urandom_range(0, 40)), 16'($urandom)});
        else if (r < 34) cyc(1, 2'($urandom_range(2, 3)), $urandom);
        else             cyc(0, 2'($urandom_range(0, 3)), '0);
      end
    end

    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule